// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Sequencer

This block runs a single DMA channel from a list of command descriptors kept in memory. Software points the channel at the first descriptor and grants it credits by adding to a semaphore counter. While the counter is nonzero, the sequencer fetches each descriptor through a one-word request/response read port and decodes its control word. It pushes any register-load words out to the peripheral. For transfer commands it then drives a data mover through a byte-count handshake and advances the current buffer address as bytes move. When the descriptor completes, the sequencer either follows the link pointer or stops.

Descriptors occupy consecutive 32-bit words. Word 0 is the link pointer. Word 1 carries the control field in bits [15:0] and the byte count in bits [31:16]. Word 2 is the buffer address. Words 3 and up are the register-load words. Completion, bus-error and termination events leave the block as one-cycle strobes. The next-command address, the semaphore and the current buffer address are visible as outputs.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset the outputs are at rest: `cmd_addr`, `sema_cnt` and `buf_addr` are 0, and `mem_req`, `xfer_req`, `busy`, `pio_we` and all three strobes are low.
- R2: A `cmd_wr` pulse while the channel is not busy loads `cmd_addr` and arms the channel. An armed channel issues no memory read while `sema_cnt` is 0. It begins fetching at `cmd_addr` as soon as the counter is nonzero.
- R3: A `sema_wr` pulse adds `sema_wdata` to the counter. The counter saturates at all ones and never wraps.
- R4: Descriptor words are read in order from `cmd_addr`, `cmd_addr+4`, `cmd_addr+8` and onward. Word 1 bits [1:0] are the opcode, bit 2 is link, bit 3 is interrupt, bit 6 is decrement, bit 8 is stop-on-terminate, and bits [15:12] are the register-load word count N. Bits [31:16] are the byte count.
- R5: The N register-load words appear on `pio_data` with one `pio_we` pulse each, and `pio_idx` counts 0 to N-1 in fetch order.
- R6: Opcode 1 (peripheral to memory, `xfer_dir`=1) and opcode 2 (memory to peripheral, `xfer_dir`=0) run a data phase. Opcodes 0 and 3 finish without raising `xfer_req`.
- R7: `buf_addr` loads from word 2. Each `xfer_step` during the data phase moves min(4, remaining) bytes and advances it by that amount. The phase ends when the count is used up, so a zero count moves nothing.
- R8: A finishing descriptor with the decrement bit lowers the counter by one. If the counter is then 0 and the link bit is set, the channel waits idle and resumes when software adds credit.
- R9: With the link bit set, `cmd_addr` takes the link pointer at completion and the chain continues, so a ring repeats while credit lasts. Without it, the channel stops, keeps `cmd_addr`, and ignores credit until the next `cmd_wr`.
- R10: `done_irq` pulses for exactly one cycle per finished descriptor whose interrupt bit is set, and never for other descriptors.
- R11: A read response with `mem_rerr`, or `xfer_err` during the data phase, pulses `bus_err` and stops the channel without completion, decrement or interrupt.
- R12: A transfer opcode with a byte count above 0xFF00 pulses `bus_err` and stops the channel before any data phase.
- R13: `term_in` during the data phase pulses `term_evt`. With the stop-on-terminate bit set, the channel stops without completing the descriptor. With it clear, the transfer runs to completion. `term_in` outside the data phase has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Write strobe for the next-command address |
| cmd_wdata | input | 32 | Address of the first descriptor |
| sema_wr | input | 1 | Add strobe for the semaphore |
| sema_wdata | input | 8 | Value added to the semaphore |
| mem_req | output | 1 | Descriptor word read request, held until answered |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| mem_rerr | input | 1 | Read response carries an error |
| pio_we | output | 1 | Register-load word strobe |
| pio_idx | output | 4 | Index of the register-load word |
| pio_data | output | 32 | Register-load word value |
| xfer_req | output | 1 | Data phase active |
| xfer_dir | output | 1 | 1 = peripheral to memory, 0 = memory to peripheral |
| xfer_step | input | 1 | Mover moved one beat of up to 4 bytes |
| xfer_err | input | 1 | Mover reports a bus error |
| term_in | input | 1 | Peripheral terminate request |
| cmd_addr | output | 32 | Next-command address register |
| sema_cnt | output | 8 | Semaphore counter |
| buf_addr | output | 32 | Current buffer address |
| busy | output | 1 | Fetching, transferring or finishing a descriptor |
| done_irq | output | 1 | Completion strobe |
| bus_err | output | 1 | Bus error strobe |
| term_evt | output | 1 | Termination strobe |

## Verification
A corrupted word index would show up first on `mem_addr` during the fetch of the same descriptor, and then as register-load words with the wrong values or count on the following cycles. A wrong semaphore or link decision shows a few cycles after the descriptor completes. It appears as a ring that runs one lap too many or too few, or as a channel that stays busy when it should idle, and the counts of `done_irq` pulses and the final `cmd_addr` expose it. A buffer-count error appears as a wrong final `buf_addr` or a data phase that never ends, which the bench sees when the channel fails to go idle.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int unsigned DESC_CNT_W = 16;
  localparam int unsigned CB_CHAIN   = 2;
  localparam int unsigned CB_IRQ     = 3;
  localparam int unsigned CB_DEC     = 6;
  localparam int unsigned CB_HALT    = 8;
  localparam int unsigned CB_NPIO    = 12;

  localparam logic [1:0] OP_NONE     = 2'd0;
  localparam logic [1:0] OP_TO_MEM   = 2'd1;
  localparam logic [1:0] OP_FROM_MEM = 2'd2;

  typedef enum logic [2:0] {
    ST_STOP  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_FETCH = 3'd2,
    ST_XFER  = 3'd3,
    ST_FIN   = 3'd4
  } dcs_state_e;

  typedef struct packed {
    logic [1:0] op;
    logic       chain;
    logic       irq;
    logic       dec;
    logic       halt;
    logic [3:0] npio;
  } dcs_ctrl_t;
endpackage

// File: rtl/dcs_sema.sv
module dcs_sema #(
  parameter int unsigned SEMA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              add_en,
  input  logic [SEMA_W-1:0] add_val,
  input  logic              dec_en,
  output logic [SEMA_W-1:0] count,
  output logic [SEMA_W-1:0] count_nxt
);
  localparam logic [SEMA_W-1:0] SEMA_MAX = '1;

  logic [SEMA_W:0]   sum;
  logic [SEMA_W-1:0] sat, cnt_q, cnt_d, add_term;
  logic              cnt_en;

  always_comb begin
    add_term = add_en ? add_val : '0;
    sum      = {1'b0, cnt_q} + {1'b0, add_term};
    sat      = sum[SEMA_W] ? SEMA_MAX : sum[SEMA_W-1:0];
    cnt_d    = (dec_en && (sat != '0)) ? sat - 1'b1 : sat;
    cnt_en   = add_en | dec_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count     = cnt_q;
  assign count_nxt = cnt_d;

  // R3: without a decrement the counter never goes down (no wrap)
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_en |=> cnt_q >= $past(cnt_q));
  // R8: a lone decrement lowers a nonzero counter by exactly one
  p_dec_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && !add_en && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/dcs_mover.sv
module dcs_mover #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned BEAT_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic              step_en,
  output logic [ADDR_W-1:0] buf_addr,
  output logic              rem_zero
);
  localparam logic [CNT_W-1:0] BEAT = CNT_W'(BEAT_BYTES);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  rem_q, rem_d, step_amt;
  logic              adv, reg_en;

  always_comb begin
    step_amt = (rem_q < BEAT) ? rem_q : BEAT;
    adv      = step_en && (rem_q != '0);
    addr_d   = addr_q;
    rem_d    = rem_q;
    if (load) begin
      addr_d = load_addr;
      rem_d  = load_cnt;
    end else if (adv) begin
      addr_d = addr_q + ADDR_W'(step_amt);
      rem_d  = rem_q - step_amt;
    end
    reg_en = load | adv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else if (reg_en) begin
      addr_q <= addr_d;
      rem_q  <= rem_d;
    end
  end

  assign buf_addr = addr_q;
  assign rem_zero = (rem_q == '0);

  // R7: every accepted beat shrinks the remaining count
  p_step_shrinks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> rem_q < $past(rem_q));
  // R7: no beat and no load leaves the buffer address untouched
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step_en) |=> $stable(addr_q));
endmodule

// File: rtl/dcs_seq.sv
module dcs_seq
  import dcs_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned SEMA_W  = 8,
  parameter int unsigned MAX_CNT = 16'hFF00
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_wr,
  input  logic [ADDR_W-1:0]     cmd_wdata,
  input  logic [SEMA_W-1:0]     sema_cnt,
  input  logic [SEMA_W-1:0]     sema_nxt,
  output logic                  sema_dec,
  output logic                  mem_req,
  output logic [ADDR_W-1:0]     mem_addr,
  input  logic                  mem_rvalid,
  input  logic [31:0]           mem_rdata,
  input  logic                  mem_rerr,
  output logic                  pio_we,
  output logic [3:0]            pio_idx,
  output logic [31:0]           pio_data,
  output logic                  xfer_req,
  output logic                  xfer_dir,
  input  logic                  xfer_err,
  input  logic                  term_in,
  input  logic                  rem_zero,
  output logic                  buf_load,
  output logic [DESC_CNT_W-1:0] buf_cnt,
  output logic [ADDR_W-1:0]     cmd_addr,
  output logic                  busy,
  output logic                  done_irq,
  output logic                  bus_err,
  output logic                  term_evt
);
  localparam int unsigned IDX_W = 5;
  localparam logic [DESC_CNT_W-1:0] CNT_LIMIT = DESC_CNT_W'(MAX_CNT);

  dcs_state_e            state_q, state_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [ADDR_W-1:0]     cmd_q, cmd_d, link_q, link_d;
  dcs_ctrl_t             ctrl_q, ctrl_d;
  logic [DESC_CNT_W-1:0] cnt_q, cnt_d;
  logic                  pio_we_q, pio_we_d, irq_q, irq_d, berr_q, berr_d, term_q, term_d;
  logic [3:0]            pio_idx_q, pio_idx_d;
  logic [31:0]           pio_data_q, pio_data_d;
  logic                  last_word, is_xfer, too_big, word_ok;
  logic [5:0]            ctrl_word_unused;

  assign ctrl_word_unused = {mem_rdata[11:9], mem_rdata[7], mem_rdata[5:4]};
  assign last_word = (idx_q == (5'd2 + {1'b0, ctrl_q.npio}));
  assign is_xfer   = (ctrl_q.op == OP_TO_MEM) || (ctrl_q.op == OP_FROM_MEM);
  assign too_big   = (cnt_q > CNT_LIMIT);
  assign word_ok   = (state_q == ST_FETCH) && mem_rvalid && !mem_rerr;
  assign sema_dec  = (state_q == ST_FIN) && ctrl_q.dec;
  assign buf_load  = word_ok && (idx_q == 5'd2);
  assign buf_cnt   = cnt_q;

  always_comb begin
    state_d    = state_q;
    idx_d      = idx_q;
    cmd_d      = cmd_q;
    link_d     = link_q;
    ctrl_d     = ctrl_q;
    cnt_d      = cnt_q;
    pio_we_d   = 1'b0;
    pio_idx_d  = pio_idx_q;
    pio_data_d = pio_data_q;
    irq_d      = 1'b0;
    berr_d     = 1'b0;
    term_d     = 1'b0;
    unique case (state_q)
      ST_STOP: begin
        if (cmd_wr) begin
          cmd_d   = cmd_wdata;
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (cmd_wr) cmd_d = cmd_wdata;
        if (sema_cnt != '0) begin
          state_d = ST_FETCH;
          idx_d   = '0;
        end
      end
      ST_FETCH: begin
        if (mem_rvalid && mem_rerr) begin
          berr_d  = 1'b1;
          state_d = ST_STOP;
        end else if (mem_rvalid) begin
          idx_d = idx_q + 5'd1;
          case (idx_q)
            5'd0: link_d = mem_rdata;
            5'd1: begin
              ctrl_d.op    = mem_rdata[1:0];
              ctrl_d.chain = mem_rdata[CB_CHAIN];
              ctrl_d.irq   = mem_rdata[CB_IRQ];
              ctrl_d.dec   = mem_rdata[CB_DEC];
              ctrl_d.halt  = mem_rdata[CB_HALT];
              ctrl_d.npio  = mem_rdata[CB_NPIO +: 4];
              cnt_d        = mem_rdata[31:16];
            end
            5'd2: ;
            default: begin
              pio_we_d   = 1'b1;
              pio_idx_d  = 4'(idx_q - 5'd3);
              pio_data_d = mem_rdata;
            end
          endcase
          if (last_word) begin
            idx_d = '0;
            if (!is_xfer) begin
              state_d = ST_FIN;
            end else if (too_big) begin
              berr_d  = 1'b1;
              state_d = ST_STOP;
            end else begin
              state_d = ST_XFER;
            end
          end
        end
      end
      ST_XFER: begin
        if (xfer_err) begin
          berr_d  = 1'b1;
          state_d = ST_STOP;
        end else begin
          term_d = term_in;
          if (term_in && ctrl_q.halt) state_d = ST_STOP;
          else if (rem_zero)          state_d = ST_FIN;
        end
      end
      ST_FIN: begin
        irq_d = ctrl_q.irq;
        if (ctrl_q.chain) begin
          cmd_d   = link_q;
          idx_d   = '0;
          state_d = (sema_nxt != '0) ? ST_FETCH : ST_WAIT;
        end else begin
          state_d = ST_STOP;
        end
      end
      default: state_d = ST_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_STOP;
      idx_q      <= '0;
      cmd_q      <= '0;
      link_q     <= '0;
      ctrl_q     <= '0;
      cnt_q      <= '0;
      pio_we_q   <= 1'b0;
      pio_idx_q  <= '0;
      pio_data_q <= '0;
      irq_q      <= 1'b0;
      berr_q     <= 1'b0;
      term_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      idx_q      <= idx_d;
      cmd_q      <= cmd_d;
      link_q     <= link_d;
      ctrl_q     <= ctrl_d;
      cnt_q      <= cnt_d;
      pio_we_q   <= pio_we_d;
      pio_idx_q  <= pio_idx_d;
      pio_data_q <= pio_data_d;
      irq_q      <= irq_d;
      berr_q     <= berr_d;
      term_q     <= term_d;
    end
  end

  assign mem_req  = (state_q == ST_FETCH);
  assign mem_addr = cmd_q + ADDR_W'({idx_q, 2'b00});
  assign xfer_req = (state_q == ST_XFER);
  assign xfer_dir = (ctrl_q.op == OP_TO_MEM);
  assign busy     = (state_q == ST_FETCH) || (state_q == ST_XFER) || (state_q == ST_FIN);
  assign cmd_addr = cmd_q;
  assign pio_we   = pio_we_q;
  assign pio_idx  = pio_idx_q;
  assign pio_data = pio_data_q;
  assign done_irq = irq_q;
  assign bus_err  = berr_q;
  assign term_evt = term_q;

  // R2: no fetch starts while the semaphore is empty
  p_wait_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && sema_cnt == '0) |=> state_q != ST_FETCH);
  // R9: a linked completion moves the command address to the link pointer
  p_link_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FIN && ctrl_q.chain) |=> cmd_q == $past(link_q));
  // R11: an error and a completion never share a cycle
  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_q, berr_q}));
  // R12: an oversized transfer is rejected before any data phase
  p_oversize_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (word_ok && last_word && is_xfer && too_big) |=> (!xfer_req && bus_err));
  // R13: terminate with the stop bit ends the descriptor at once
  p_term_halt_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_XFER && term_in && ctrl_q.halt && !xfer_err) |=> (state_q == ST_STOP && term_evt));
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
  import dcs_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned SEMA_W     = 8,
  parameter int unsigned BEAT_BYTES = 4,
  parameter int unsigned MAX_CNT    = 16'hFF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [ADDR_W-1:0] cmd_wdata,
  input  logic              sema_wr,
  input  logic [SEMA_W-1:0] sema_wdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_rerr,
  output logic              pio_we,
  output logic [3:0]        pio_idx,
  output logic [31:0]       pio_data,
  output logic              xfer_req,
  output logic              xfer_dir,
  input  logic              xfer_step,
  input  logic              xfer_err,
  input  logic              term_in,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [SEMA_W-1:0] sema_cnt,
  output logic [ADDR_W-1:0] buf_addr,
  output logic              busy,
  output logic              done_irq,
  output logic              bus_err,
  output logic              term_evt
);
  logic [1:0]            rst_pipe;
  logic                  rst_n_sync;
  logic [SEMA_W-1:0]     sema_nxt;
  logic                  sema_dec, rem_zero, buf_load;
  logic [DESC_CNT_W-1:0] buf_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[1];

  dcs_sema #(.SEMA_W(SEMA_W)) u_sema (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .add_en    (sema_wr),
    .add_val   (sema_wdata),
    .dec_en    (sema_dec),
    .count     (sema_cnt),
    .count_nxt (sema_nxt)
  );

  dcs_mover #(.ADDR_W(ADDR_W), .CNT_W(DESC_CNT_W), .BEAT_BYTES(BEAT_BYTES)) u_mover (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .load      (buf_load),
    .load_addr (mem_rdata[ADDR_W-1:0]),
    .load_cnt  (buf_cnt),
    .step_en   (xfer_step & xfer_req),
    .buf_addr  (buf_addr),
    .rem_zero  (rem_zero)
  );

  dcs_seq #(.ADDR_W(ADDR_W), .SEMA_W(SEMA_W), .MAX_CNT(MAX_CNT)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .cmd_wr     (cmd_wr),
    .cmd_wdata  (cmd_wdata),
    .sema_cnt   (sema_cnt),
    .sema_nxt   (sema_nxt),
    .sema_dec   (sema_dec),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .mem_rerr   (mem_rerr),
    .pio_we     (pio_we),
    .pio_idx    (pio_idx),
    .pio_data   (pio_data),
    .xfer_req   (xfer_req),
    .xfer_dir   (xfer_dir),
    .xfer_err   (xfer_err),
    .term_in    (term_in),
    .rem_zero   (rem_zero),
    .buf_load   (buf_load),
    .buf_cnt    (buf_cnt),
    .cmd_addr   (cmd_addr),
    .busy       (busy),
    .done_irq   (done_irq),
    .bus_err    (bus_err),
    .term_evt   (term_evt)
  );
endmodule

// File: tb/dma_chain_seq_bench.sv
module dma_chain_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic        sema_wr = 1'b0;
  logic [7:0]  sema_wdata = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        mem_rerr = 1'b0;
  logic        pio_we;
  logic [3:0]  pio_idx;
  logic [31:0] pio_data;
  logic        xfer_req, xfer_dir;
  logic        xfer_step = 1'b0;
  logic        xfer_err = 1'b0;
  logic        term_in = 1'b0;
  logic [31:0] cmd_addr, buf_addr;
  logic [7:0]  sema_cnt;
  logic        busy, done_irq, bus_err, term_evt;

  always #2 clk = ~clk;

  dma_chain_seq u_dma_chain_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .sema_wr(sema_wr), .sema_wdata(sema_wdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_rerr(mem_rerr),
    .pio_we(pio_we), .pio_idx(pio_idx), .pio_data(pio_data),
    .xfer_req(xfer_req), .xfer_dir(xfer_dir), .xfer_step(xfer_step), .xfer_err(xfer_err),
    .term_in(term_in), .cmd_addr(cmd_addr), .sema_cnt(sema_cnt), .buf_addr(buf_addr),
    .busy(busy), .done_irq(done_irq), .bus_err(bus_err), .term_evt(term_evt)
  );

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] mem [0:127];
  int dly = 0;
  logic        err_en = 1'b0;
  logic [31:0] err_addr = '0;
  logic        term_arm = 1'b0, xerr_arm = 1'b0, log_en = 1'b0;
  int n_done = 0, n_berr = 0, n_term = 0, n_xfer = 0, n_pio = 0, n_addr = 0;
  logic        last_dir = 1'b0;
  logic [3:0]  pio_idx_log [0:15];
  logic [31:0] pio_dat_log [0:15];
  logic [31:0] addr_log [0:15];

  function automatic logic [15:0] mk_ctrl(input logic [1:0] op, input logic chain, input logic irq,
                                          input logic dec, input logic halt, input logic [3:0] npio);
    return {npio, 3'b000, halt, 1'b0, dec, 2'b00, irq, chain, op};
  endfunction
  function automatic logic [7:0] sat_add(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s = {1'b0, a} + {1'b0, b};
    return s[8] ? 8'hFF : s[7:0];
  endfunction
  function automatic logic [31:0] end_addr(input logic [31:0] b, input logic [15:0] n);
    return b + {16'd0, n};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic put_desc(input int base, input logic [31:0] nxt, input logic [15:0] ctrl,
                          input logic [15:0] cnt, input logic [31:0] b,
                          input logic [31:0] p0, input logic [31:0] p1, input logic [31:0] p2);
    mem[base/4]   = nxt;
    mem[base/4+1] = {cnt, ctrl};
    mem[base/4+2] = b;
    mem[base/4+3] = p0;
    mem[base/4+4] = p1;
    mem[base/4+5] = p2;
  endtask

  task automatic do_cmd(input logic [31:0] a);
    @(negedge clk); cmd_wr = 1'b1; cmd_wdata = a;
    @(negedge clk); cmd_wr = 1'b0;
  endtask
  task automatic do_sema(input logic [7:0] v);
    @(negedge clk); sema_wr = 1'b1; sema_wdata = v;
    @(negedge clk); sema_wr = 1'b0;
  endtask
  task automatic wait_idle();
    int n = 0;
    while (!busy && n < 50) begin @(negedge clk); n++; end
    n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
  endtask

  // memory responder, mover and monitors: all on the falling edge
  always @(negedge clk) begin
    if (mem_rvalid) begin
      mem_rvalid = 1'b0;
      mem_rerr   = 1'b0;
      dly        = int'($urandom % 3);
    end else if (mem_req) begin
      if (dly == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = mem[mem_addr[8:2]];
        mem_rerr   = err_en && (mem_addr == err_addr);
        if (log_en && n_addr < 16) begin addr_log[n_addr] = mem_addr; n_addr++; end
      end else dly--;
    end
    xfer_step = xfer_req && ($urandom % 3 != 0);
    if (term_arm && xfer_req) begin term_in = 1'b1; term_arm = 1'b0; end
    else term_in = 1'b0;
    if (xerr_arm && xfer_req) begin xfer_err = 1'b1; xerr_arm = 1'b0; end
    else xfer_err = 1'b0;
    if (done_irq) n_done++;
    if (bus_err)  n_berr++;
    if (term_evt) n_term++;
    if (xfer_req) begin n_xfer++; last_dir = xfer_dir; end
    if (pio_we && n_pio < 16) begin pio_idx_log[n_pio] = pio_idx; pio_dat_log[n_pio] = pio_data; n_pio++; end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] c0, c1;
    int d0, b0, t0, x0;
    void'($urandom(32'd1234));
    for (int i = 0; i < 128; i++) mem[i] = 32'h0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 cmd_addr", cmd_addr, 0);
    chk("R1 sema_cnt", {24'd0, sema_cnt}, 0);
    chk("R1 buf_addr", buf_addr, 0);
    chk("R1 quiet outputs", {28'd0, mem_req, xfer_req, busy, done_irq | bus_err | term_evt | pio_we}, 0);

    // single descriptor, memory to peripheral, two register loads, no link
    put_desc(32'h000, 32'h40, mk_ctrl(2'd2, 0, 1, 1, 0, 4'd2), 16'd10, 32'h1000,
             32'hA5A5_0001, 32'h5A5A_0002, 32'h0);
    log_en = 1'b1;
    do_cmd(32'h000);
    repeat (10) @(negedge clk);
    chk("R2 no fetch with empty semaphore", {30'd0, mem_req, busy}, 0);
    chk("R2 cmd_addr loaded", cmd_addr, 32'h000);
    do_sema(8'd1);
    wait_idle();
    log_en = 1'b0;
    chk("R4 words fetched", n_addr, 5);
    for (int i = 0; i < 5; i++) chk("R4 fetch address order", addr_log[i], 32'(4 * i));
    chk("R5 load word count", n_pio, 2);
    chk("R5 load idx 0", {28'd0, pio_idx_log[0]}, 0);
    chk("R5 load data 0", pio_dat_log[0], 32'hA5A5_0001);
    chk("R5 load idx 1", {28'd0, pio_idx_log[1]}, 1);
    chk("R5 load data 1", pio_dat_log[1], 32'hA5A5_0001 ^ 32'hFFFF_0003);
    chk("R6 direction for opcode 2", {31'd0, last_dir}, 0);
    chk("R7 buffer end", buf_addr, end_addr(32'h1000, 16'd10));
    chk("R8 semaphore after decrement", {24'd0, sema_cnt}, 0);
    chk("R10 one completion", n_done, 1);
    chk("R9 unlinked keeps cmd_addr", cmd_addr, 32'h000);
    do_sema(8'd1);
    repeat (20) @(negedge clk);
    chk("R9 stopped channel ignores credit", {31'd0, busy | mem_req}, 0);
    do_sema(8'd255);  // drain back via saturation check later; counter now saturated
    chk("R3 saturation", {24'd0, sema_cnt}, {24'd0, sat_add(8'd1, 8'd255)});
    // reset to start the ring scenario from an empty semaphore
    rst_n = 1'b0; repeat (3) @(negedge clk); rst_n = 1'b1; repeat (4) @(negedge clk);
    chk("R1 semaphore cleared by reset", {24'd0, sema_cnt}, 0);

    // ring of two linked descriptors, peripheral to memory, random counts
    c0 = 16'(1 + $urandom % 40);
    c1 = 16'(1 + $urandom % 40);
    put_desc(32'h040, 32'h060, mk_ctrl(2'd1, 1, 1, 1, 0, 4'd0), c0, 32'h2000, 0, 0, 0);
    put_desc(32'h060, 32'h040, mk_ctrl(2'd1, 1, 1, 1, 0, 4'd0), c1, 32'h2400, 0, 0, 0);
    d0 = n_done;
    do_cmd(32'h040);
    do_sema(8'd3);
    wait_idle();
    chk("R9 ring laps with three credits", n_done - d0, 3);
    chk("R9 cmd_addr after third", cmd_addr, 32'h060);
    chk("R7 buffer end ring", buf_addr, end_addr(32'h2000, c0));
    chk("R8 idle on empty semaphore", {24'd0, sema_cnt}, 0);
    chk("R6 direction for opcode 1", {31'd0, last_dir}, 1);
    do_sema(8'd1);
    wait_idle();
    chk("R8 resume after credit", n_done - d0, 4);
    chk("R9 ring wraps", cmd_addr, 32'h040);
    chk("R7 buffer end second", buf_addr, end_addr(32'h2400, c1));

    // no-transfer opcode with three loads, no decrement
    put_desc(32'h080, 32'h0, mk_ctrl(2'd0, 0, 1, 0, 0, 4'd3), 16'd77, 32'h3300,
             32'h11, 32'h22, 32'h33);
    x0 = n_xfer; d0 = n_done; n_pio = 0;
    do_cmd(32'h080);
    do_sema(8'd1);
    wait_idle();
    chk("R6 opcode 0 has no data phase", n_xfer - x0, 0);
    chk("R5 three loads", n_pio, 3);
    chk("R5 last load", pio_dat_log[2], 32'h33);
    chk("R8 no decrement keeps credit", {24'd0, sema_cnt}, 1);
    chk("R10 completion opcode 0", n_done - d0, 1);

    // oversize count
    put_desc(32'h0A0, 32'h0, mk_ctrl(2'd2, 0, 1, 1, 0, 4'd0), 16'hFF01, 32'h4000, 0, 0, 0);
    x0 = n_xfer; d0 = n_done; b0 = n_berr;
    do_cmd(32'h0A0);
    wait_idle();
    chk("R12 bus error on oversize", n_berr - b0, 1);
    chk("R12 no data phase", n_xfer - x0, 0);
    chk("R11 no completion on error", n_done - d0, 0);
    chk("R11 no decrement on error", {24'd0, sema_cnt}, 1);

    // terminate with stop bit
    put_desc(32'h0C0, 32'h0, mk_ctrl(2'd2, 0, 1, 1, 1, 4'd0), 16'd64, 32'h5000, 0, 0, 0);
    d0 = n_done; t0 = n_term;
    term_arm = 1'b1;
    do_cmd(32'h0C0);
    wait_idle();
    chk("R13 termination strobe", n_term - t0, 1);
    chk("R13 halted without completion", n_done - d0, 0);
    chk("R13 halted keeps credit", {24'd0, sema_cnt}, 1);
    chk("R13 halted early", {31'd0, buf_addr < end_addr(32'h5000, 16'd64)}, 1);

    // terminate without stop bit
    put_desc(32'h0E0, 32'h0, mk_ctrl(2'd2, 0, 1, 1, 0, 4'd0), 16'd64, 32'h6000, 0, 0, 0);
    d0 = n_done; t0 = n_term;
    term_arm = 1'b1;
    do_cmd(32'h0E0);
    wait_idle();
    chk("R13 strobe without stop bit", n_term - t0, 1);
    chk("R13 runs to completion", n_done - d0, 1);
    chk("R13 full count moved", buf_addr, end_addr(32'h6000, 16'd64));

    // fetch error on word 1
    put_desc(32'h100, 32'h0, mk_ctrl(2'd2, 0, 1, 1, 0, 4'd0), 16'd8, 32'h7000, 0, 0, 0);
    err_en = 1'b1; err_addr = 32'h104;
    d0 = n_done; b0 = n_berr;
    do_cmd(32'h100);
    do_sema(8'd1);
    wait_idle();
    err_en = 1'b0;
    chk("R11 fetch error strobe", n_berr - b0, 1);
    chk("R11 fetch error no completion", n_done - d0, 0);

    // mover error during data phase
    put_desc(32'h120, 32'h0, mk_ctrl(2'd1, 0, 1, 1, 0, 4'd0), 16'd40, 32'h8000, 0, 0, 0);
    d0 = n_done; b0 = n_berr;
    xerr_arm = 1'b1;
    do_cmd(32'h120);
    wait_idle();
    chk("R11 mover error strobe", n_berr - b0, 1);
    chk("R11 mover error keeps credit", {24'd0, sema_cnt}, 1);

    // terminate outside data phase is ignored
    t0 = n_term;
    @(negedge clk); term_in = 1'b1;
    repeat (5) @(negedge clk);
    chk("R13 idle terminate ignored", n_term - t0, 0);
    chk("R13 idle terminate keeps idle", {31'd0, busy}, 0);

    do_sema(8'd200);
    do_sema(8'd100);
    chk("R3 saturating add", {24'd0, sema_cnt}, {24'd0, sat_add(sat_add(8'd1, 8'd200), 8'd100)});
    repeat (4) @(negedge clk);
    chk("R10 no stray completion", {31'd0, done_irq}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule